// File: doc/BRIEF.md
# Memory controller operating state sequencer

This block holds the top-level operating state of a DRAM protocol controller. Software changes the state by writing command codes through a simple register write port. Each accepted change first passes through a transient request state. The block leaves that state only when the command scheduler reports that it is idle. The current state and the source of the latest low-power entry are reported in an 8-bit status word. A scheduler traffic enable and a DRAM low-power request are driven from registers.

A hardware low-power mode can be enabled through the same write port. While it is enabled, a level trigger input moves the block from access into low power without any software action. Once the trigger falls, the block returns to access by itself. Leaving low power always lands in access. A config request from low power therefore needs a wakeup command first.

Top module: `mc_opstate_seq`

## Requirements
- R1: After a synchronous reset the state code is 0 (init-memory), the trigger source is 0, and both traffic_en and lp_req are low.
- R2: stat_word carries the state code in bits 2:0 and the trigger source in bits 6:4; bits 3 and 7 read 0. State codes: 0 init-memory, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. Source codes: 0 none, 1 hardware, 2 software.
- R3: A write of command 1 (config) in init-memory or access moves the state to 2 on the next edge, and then to 1.
- R4: A write of command 2 (go) in config moves the state to 4, and then to 3.
- R5: A write of command 3 (sleep) in access moves the state to 6 with source 2, and then to 5.
- R6: A write of command 4 (wakeup) in low-power moves the state to 7, and then to 3. The source returns to 0 when access is reached.
- R7: The block spends at least one cycle in a request state (2, 4, 6, 7). It stays there while sched_idle is low and moves to its target on the first edge at which sched_idle is high.
- R8: Illegal writes leave the state and source unchanged. These are command 0 (init), codes 5 to 7, any command not listed for the current state (config in low-power included), and any write during a request state.
- R9: Every write loads wr_lp_en into the hardware low-power enable, which takes effect from the next cycle. While the enable is 1 and lp_trig is high in access, the state moves to 6 with source 1 and then to 5. While the enable is 0, the trigger has no effect.
- R10: In low-power with source 1, a low lp_trig moves the state to 7 and then to 3. In low-power with source 2, lp_trig has no effect.
- R11: traffic_en is high exactly while the state is 3. lp_req is high exactly while the state is 5 or 6.
- R12: In access, a legal command write in the same cycle as an enabled trigger wins over the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_cmd | input | 3 | Command code written |
| wr_lp_en | input | 1 | Hardware low-power enable written with the command |
| sched_idle | input | 1 | Scheduler reports no traffic in flight |
| lp_trig | input | 1 | Hardware low-power trigger level |
| stat_word | output | 8 | Status: state code and trigger source |
| traffic_en | output | 1 | Scheduler may issue traffic |
| lp_req | output | 1 | DRAM low-power request |

## Verification
The bench starts from each stable state: init-memory, config, access and software low-power. In each one it writes every 3-bit command code with the scheduler held busy. This separates accepted commands, which show their request state, from ignored ones, which leave the state as it was. It also checks that the request state holds until the scheduler goes idle and lands on the right target. Separate sequences cover the hardware trigger with the enable off, on, and raised together with a software command. A further sequence writes while a request is pending. These show that the trigger path and the source field are kept apart from the software path.

// File: rtl/mc_opstate_pkg.sv
package mc_opstate_pkg;
  localparam int ST_W   = 3;
  localparam int CMD_W  = 3;
  localparam int SRC_W  = 3;
  localparam int STAT_W = 8;

  typedef enum logic [ST_W-1:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LPE_REQ = 3'd6,
    ST_LPX_REQ = 3'd7
  } opst_e;

  localparam logic [CMD_W-1:0] CMD_INIT  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_CFG   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GO    = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKE  = 3'd4;

  localparam logic [SRC_W-1:0] SRC_NONE = 3'd0;
  localparam logic [SRC_W-1:0] SRC_HW   = 3'd1;
  localparam logic [SRC_W-1:0] SRC_SW   = 3'd2;

  function automatic logic is_req(input logic [ST_W-1:0] s);
    return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
           (s == ST_LPE_REQ) || (s == ST_LPX_REQ);
  endfunction
endpackage

// File: rtl/mc_opstate_ctlreg.sv
module mc_opstate_ctlreg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_lp_en,
  output logic hw_lp_en
);
  always_ff @(posedge clk) begin
    if (rst)        hw_lp_en <= 1'b0;
    else if (wr_en) hw_lp_en <= wr_lp_en;
  end
endmodule

// File: rtl/mc_opstate_decode.sv
module mc_opstate_decode
  import mc_opstate_pkg::*;
(
  input  opst_e             cur_st,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic              hw_lp_en,
  input  logic              lp_trig,
  input  logic              sched_idle,
  output opst_e             nxt_st,
  output logic [SRC_W-1:0]  nxt_src
);
  logic cmd_cfg, cmd_go, cmd_sleep, cmd_wake, hw_enter;

  always_comb begin
    cmd_cfg   = wr_en && (wr_cmd == CMD_CFG);
    cmd_go    = wr_en && (wr_cmd == CMD_GO);
    cmd_sleep = wr_en && (wr_cmd == CMD_SLEEP);
    cmd_wake  = wr_en && (wr_cmd == CMD_WAKE);
    hw_enter  = hw_lp_en && lp_trig;
  end

  always_comb begin
    nxt_st  = cur_st;
    nxt_src = cur_src;
    unique case (cur_st)
      ST_INIT: begin
        if (cmd_cfg) nxt_st = ST_CFG_REQ;
      end
      ST_CFG: begin
        if (cmd_go) nxt_st = ST_ACC_REQ;
      end
      ST_ACC: begin
        if (cmd_cfg) begin
          nxt_st = ST_CFG_REQ;
        end else if (cmd_sleep) begin
          nxt_st  = ST_LPE_REQ;
          nxt_src = SRC_SW;
        end else if (hw_enter) begin
          nxt_st  = ST_LPE_REQ;
          nxt_src = SRC_HW;
        end
      end
      ST_LP: begin
        if (cmd_wake || ((cur_src == SRC_HW) && !lp_trig))
          nxt_st = ST_LPX_REQ;
      end
      ST_CFG_REQ: if (sched_idle) nxt_st = ST_CFG;
      ST_ACC_REQ: if (sched_idle) nxt_st = ST_ACC;
      ST_LPE_REQ: if (sched_idle) nxt_st = ST_LP;
      ST_LPX_REQ: begin
        if (sched_idle) begin
          nxt_st  = ST_ACC;
          nxt_src = SRC_NONE;
        end
      end
      default: nxt_st = ST_INIT;
    endcase
  end
endmodule

// File: rtl/mc_opstate_regs.sv
module mc_opstate_regs
  import mc_opstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  opst_e             nxt_st,
  input  logic [SRC_W-1:0]  nxt_src,
  output opst_e             st_q,
  output logic [SRC_W-1:0]  src_q,
  output logic              traffic_en,
  output logic              lp_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_INIT;
      src_q      <= SRC_NONE;
      traffic_en <= 1'b0;
      lp_req     <= 1'b0;
    end else begin
      st_q       <= nxt_st;
      src_q      <= nxt_src;
      traffic_en <= (nxt_st == ST_ACC);
      lp_req     <= (nxt_st == ST_LP) || (nxt_st == ST_LPE_REQ);
    end
  end
endmodule

// File: rtl/mc_opstate_seq.sv
module mc_opstate_seq
  import mc_opstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_cmd,
  input  logic              wr_lp_en,
  input  logic              sched_idle,
  input  logic              lp_trig,
  output logic [STAT_W-1:0] stat_word,
  output logic              traffic_en,
  output logic              lp_req
);
  localparam int PAD_W = STAT_W - ST_W - SRC_W - 1;

  logic             hw_lp_en;
  opst_e            st_q, nxt_st;
  logic [SRC_W-1:0] src_q, nxt_src;

  mc_opstate_ctlreg u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lp_en(wr_lp_en), .hw_lp_en(hw_lp_en)
  );

  mc_opstate_decode u_dec (
    .cur_st(st_q), .cur_src(src_q), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .hw_lp_en(hw_lp_en), .lp_trig(lp_trig), .sched_idle(sched_idle),
    .nxt_st(nxt_st), .nxt_src(nxt_src)
  );

  mc_opstate_regs u_regs (
    .clk(clk), .rst(rst), .nxt_st(nxt_st), .nxt_src(nxt_src),
    .st_q(st_q), .src_q(src_q), .traffic_en(traffic_en), .lp_req(lp_req)
  );

  assign stat_word = {{PAD_W{1'b0}}, src_q, 1'b0, st_q};
endmodule

// File: rtl/mc_opstate_seq_chk.sv
module mc_opstate_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sched_idle,
  input logic [7:0] stat_word,
  input logic       traffic_en,
  input logic       lp_req
);
  logic [2:0] st;
  logic [2:0] src;
  logic       rq;
  assign st  = stat_word[2:0];
  assign src = stat_word[6:4];
  assign rq  = (st == 3'd2) || (st == 3'd4) || (st == 3'd6) || (st == 3'd7);

  a_r1_init_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat_word == 8'h00 && !traffic_en && !lp_req));
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_word[3] == 1'b0 && stat_word[7] == 1'b0));
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rq && !sched_idle) |=> (st == $past(st)));
  a_r3_cfg_done: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd2 && sched_idle) |=> (st == 3'd1));
  a_r8_lp_exit_only: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd5) |=> (st == 3'd5 || st == 3'd7));
  a_r6_src_clear: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd3) |-> (src == 3'd0));
  a_r11_traffic: assert property (@(posedge clk) disable iff (rst)
    traffic_en == (st == 3'd3));
  a_r11_lpreq: assert property (@(posedge clk) disable iff (rst)
    lp_req == (st == 3'd5 || st == 3'd6));
endmodule

bind mc_opstate_seq mc_opstate_seq_chk u_chk (
  .clk(clk), .rst(rst), .sched_idle(sched_idle), .stat_word(stat_word),
  .traffic_en(traffic_en), .lp_req(lp_req)
);

// File: tb/mc_opstate_seq_bench.sv
module mc_opstate_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_cmd = 3'd0;
  logic       wr_lp_en = 1'b0;
  logic       sched_idle = 1'b1;
  logic       lp_trig = 1'b0;
  logic [7:0] stat_word;
  logic       traffic_en, lp_req;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  mc_opstate_seq u_mc_opstate_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_lp_en(wr_lp_en),
    .sched_idle(sched_idle), .lp_trig(lp_trig), .stat_word(stat_word),
    .traffic_en(traffic_en), .lp_req(lp_req)
  );

  function automatic logic [7:0] word(input logic [2:0] s, input logic [2:0] src);
    return {1'b0, src, 1'b0, s};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req, input logic [2:0] s);
    chk(req, {6'd0, traffic_en, lp_req},
        {6'd0, (s == 3'd3), (s == 3'd5 || s == 3'd6)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; lp_trig = 1'b0; sched_idle = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one write, then one cycle for the request state to resolve (idle high)
  task automatic issue(input logic [2:0] c, input logic lpen);
    wr_en = 1'b1; wr_cmd = c; wr_lp_en = lpen;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic goto_state(input int which);
    do_reset();
    sched_idle = 1'b1;
    if (which >= 1) issue(3'd1, 1'b0);
    if (which >= 2) issue(3'd2, 1'b0);
    if (which >= 3) issue(3'd3, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] starts [4];
    logic [2:0] st0, rq, tg, s0, ts;
    starts[0] = 3'd0; starts[1] = 3'd1; starts[2] = 3'd3; starts[3] = 3'd5;

    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 reset status", stat_word, 8'h00);
    chk_outs("R1 reset outputs", 3'd0);

    // Sweep: every stable start state x every command code, scheduler busy
    for (int w = 0; w < 4; w++) begin
      for (int c = 0; c < 8; c++) begin
        goto_state(w);
        st0 = starts[w];
        s0  = (w == 3) ? 3'd2 : 3'd0;
        rq = st0; tg = st0; ts = s0;
        if ((st0 == 3'd0 || st0 == 3'd3) && c == 1) begin rq = 3'd2; tg = 3'd1; end
        if (st0 == 3'd1 && c == 2) begin rq = 3'd4; tg = 3'd3; end
        if (st0 == 3'd3 && c == 3) begin rq = 3'd6; tg = 3'd5; ts = 3'd2; end
        if (st0 == 3'd5 && c == 4) begin rq = 3'd7; tg = 3'd3; ts = 3'd0; end
        chk("R2 start state", stat_word, word(st0, s0));
        sched_idle = 1'b0;
        wr_en = 1'b1; wr_cmd = c[2:0]; wr_lp_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        // R3 R4 R5 R6 R8: request state or unchanged
        chk("R3/R4/R5/R6/R8 after write", stat_word,
            word(rq, (rq == 3'd6) ? 3'd2 : s0));
        @(negedge clk);
        chk("R7 hold while busy", stat_word, word(rq, (rq == 3'd6) ? 3'd2 : s0));
        sched_idle = 1'b1;
        @(negedge clk);
        chk("R7 target after idle", stat_word, word(tg, ts));
        chk_outs("R11 outputs", tg);
      end
    end

    // R8: writes during a request state are ignored
    do_reset();
    sched_idle = 1'b0;
    issue(3'd1, 1'b0);
    chk("R8 in config-request", stat_word, word(3'd2, 3'd0));
    wr_en = 1'b1; wr_cmd = 3'd2;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 go during request ignored", stat_word, word(3'd2, 3'd0));
    sched_idle = 1'b1;
    @(negedge clk);
    chk("R8 lands on config", stat_word, word(3'd1, 3'd0));
    @(negedge clk);
    chk("R8 no late go", stat_word, word(3'd1, 3'd0));

    // R9: trigger with enable off has no effect
    goto_state(2);
    lp_trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 trigger ignored when disabled", stat_word, word(3'd3, 3'd0));
    lp_trig = 1'b0;
    // enable via a write of the ignored init command
    issue(3'd0, 1'b1);
    chk("R8 init command ignored", stat_word, word(3'd3, 3'd0));
    lp_trig = 1'b1;
    @(negedge clk);
    chk("R9 hw entry request", stat_word, word(3'd6, 3'd1));
    chk_outs("R11 lp_req in entry", 3'd6);
    @(negedge clk);
    chk("R9 hw low-power", stat_word, word(3'd5, 3'd1));
    repeat (2) @(negedge clk);
    chk("R10 stays while trigger high", stat_word, word(3'd5, 3'd1));
    // R8: config write in low-power ignored
    issue(3'd1, 1'b1);
    chk("R8 config in low-power ignored", stat_word, word(3'd5, 3'd1));
    lp_trig = 1'b0;
    @(negedge clk);
    chk("R10 hw exit request", stat_word, word(3'd7, 3'd1));
    @(negedge clk);
    chk("R10 back to access", stat_word, word(3'd3, 3'd0));
    chk_outs("R11 access outputs", 3'd3);

    // R12: legal command wins over enabled trigger
    wr_en = 1'b1; wr_cmd = 3'd1; wr_lp_en = 1'b1; lp_trig = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 command beats trigger", stat_word, word(3'd2, 3'd0));
    @(negedge clk);
    chk("R12 config reached", stat_word, word(3'd1, 3'd0));
    repeat (2) @(negedge clk);
    chk("R9 trigger no effect in config", stat_word, word(3'd1, 3'd0));
    lp_trig = 1'b0;

    // R10: software low-power ignores trigger changes
    issue(3'd2, 1'b1);
    issue(3'd3, 1'b1);
    chk("R5 sw low-power", stat_word, word(3'd5, 3'd2));
    lp_trig = 1'b1;
    @(negedge clk);
    lp_trig = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 sw low-power ignores trigger", stat_word, word(3'd5, 3'd2));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule